// File: doc/BRIEF.md
# Capture/Reload 16-bit Timer

This block is a 16-bit up-counter whose behaviour is chosen by a single control byte. The count is advanced either by a free-running clock-enable tick or by falling edges seen on an external count pin. A second external pin acts as a trigger. Depending on the control byte, a falling edge on the trigger pin either copies the live count into a 16-bit capture/reload register or reloads the counter from that register. A rollover either wraps the counter to zero or reloads it.

Setting either of the two serial-clock select bits turns the block into a baud-rate generator. In that mode the counter always reloads on rollover and every rollover produces a one-cycle pulse for a serial port. The overflow flag stays clear and the trigger pin has no effect. Software reaches the control byte, the counter and the capture/reload register through a byte-wide write port and a combinational read port. A level interrupt request is raised while either sticky flag is set.

Top module: `capture_reload_timer`

## Requirements
- R1: After a synchronous reset the control byte, the counter, the capture/reload register and all four flag and pulse outputs read 0.
- R2: The counter holds its value while run (control bit 2) is 0. With run 1 and count-source select (control bit 1) 0, it adds one on every clock with `tick_en` high.
- R3: With run 1 and count-source select 1, the counter adds one exactly once per high-to-low transition of `cnt_pin`. `cnt_pin` passes through a two-flop synchronizer, so the count changes on the third rising clock edge after the pin falls.
- R4: A count step taken at 0xFFFF is a rollover. Outside baud mode a rollover sets the overflow flag (control bit 7). The flag stays set until software writes a 0 to bit 7. With capture mode selected (control bit 0 = 1) and baud mode off, the counter wraps to 0x0000.
- R5: With control bit 0 = 0, or in baud mode, a rollover loads the counter from the capture/reload register.
- R6: With trigger enable (control bit 3) 1, baud mode off and capture selected, a falling edge of `trig_pin` (synchronized like `cnt_pin`) copies the count before that edge's step into the capture/reload register. It also sets the external flag (control bit 6), which only software clears. The counter keeps counting.
- R7: With trigger enable 1, baud mode off and control bit 0 = 0, a falling edge of `trig_pin` loads the counter from the capture/reload register and sets the external flag.
- R8: With trigger enable 0, falling edges of `trig_pin` change neither the external flag, the counter nor the capture/reload register.
- R9: Baud mode is on while receive-clock select (bit 5) or transmit-clock select (bit 4) is 1. In baud mode a rollover never sets the overflow flag, `trig_pin` edges are ignored, and `baud_pulse` is high for exactly the one cycle that follows each rollover.
- R10: `irq` is high exactly while the overflow flag or the external flag is 1.
- R11: Register addresses: 0 control, 1 counter low byte, 2 counter high byte, 3 capture/reload low byte, 4 capture/reload high byte. A write takes effect at the clock edge and overrides any hardware update of the same byte. A hardware flag set in the same cycle as a control write still sets its flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Timer clock enable, one step per high cycle |
| cnt_pin | input | 1 | External count pin (asynchronous) |
| trig_pin | input | 1 | External trigger pin (asynchronous) |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 8 | Register read data (combinational) |
| ovf_flag | output | 1 | Sticky overflow flag |
| ext_flag | output | 1 | Sticky external trigger flag |
| irq | output | 1 | Interrupt request |
| baud_pulse | output | 1 | One-cycle pulse per rollover in baud mode |

## Verification
A wrong mode decode shows up at the first rollover or trigger edge. In the cycle after it, the counter value, the capture/reload register or the flags read back through the register port will differ, so the error appears one clock after the event. A fault in the synchronizer or the edge detector shows up as a count off by one, or as an early or late change. That error appears on the third edge after the pin falls. Sticky-flag faults show up on `irq` and on the control byte in the cycle after the set or clear. A reference model compares every register and output on every clock, so each of these is caught at the cycle it occurs.

// File: rtl/crt_pkg.sv
package crt_pkg;

    typedef struct packed {
        logic ovf;
        logic ext;
        logic rx_sel;
        logic tx_sel;
        logic ext_en;
        logic run;
        logic cnt_src;
        logic cap_sel;
    } ctrl_t;

    typedef enum logic [1:0] {
        MODE_RELOAD  = 2'd0,
        MODE_CAPTURE = 2'd1,
        MODE_BAUD    = 2'd2
    } mode_e;

    localparam int CTRL_ADDR = 0;

    function automatic mode_e decode_mode(ctrl_t c);
        if (c.rx_sel || c.tx_sel) return MODE_BAUD;
        if (c.cap_sel)            return MODE_CAPTURE;
        return MODE_RELOAD;
    endfunction

endpackage

// File: rtl/crt_edge_sync.sv
module crt_edge_sync (
    input  logic clk,
    input  logic rst,
    input  logic pin,
    output logic fall
);
    logic s1, s2, prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1   <= 1'b0;
            s2   <= 1'b0;
            prev <= 1'b0;
        end else begin
            s1   <= pin;
            s2   <= s1;
            prev <= s2;
        end
    end

    assign fall = prev & ~s2;

endmodule

// File: rtl/crt_ctrl.sv
module crt_ctrl
    import crt_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr,
    input  logic [7:0] wr_data,
    input  logic       set_ovf,
    input  logic       set_ext,
    output ctrl_t      ctrl
);
    ctrl_t ctrl_n;

    always_comb begin
        ctrl_n = wr ? ctrl_t'(wr_data) : ctrl;
        if (set_ovf) ctrl_n.ovf = 1'b1;
        if (set_ext) ctrl_n.ext = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) ctrl <= '0;
        else     ctrl <= ctrl_n;
    end

    // R4: overflow flag is sticky without a software write
    a_r4_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
        (ctrl.ovf && !wr) |=> ctrl.ovf);

    // R6: external flag is sticky without a software write
    a_r6_ext_sticky: assert property (@(posedge clk) disable iff (rst)
        (ctrl.ext && !wr) |=> ctrl.ext);

    // R8: trigger enable off means the external flag cannot rise by hardware
    a_r8_no_ext_when_off: assert property (@(posedge clk) disable iff (rst)
        (!ctrl.ext_en && !wr && !ctrl.ext) |=> !ctrl.ext);

    // R9: baud mode never raises the overflow flag
    a_r9_no_ovf_in_baud: assert property (@(posedge clk) disable iff (rst)
        ((ctrl.rx_sel || ctrl.tx_sel) && !wr && !ctrl.ovf) |=> !ctrl.ovf);

endmodule

// File: rtl/crt_counter.sv
module crt_counter #(
    parameter int WIDTH = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              step,
    input  logic              reload_on_roll,
    input  logic              trig_reload,
    input  logic              trig_capture,
    input  logic [WIDTH/8-1:0] cnt_be,
    input  logic [WIDTH/8-1:0] rld_be,
    input  logic [7:0]        wr_byte,
    output logic [WIDTH-1:0]  count,
    output logic [WIDTH-1:0]  reload,
    output logic              rollover
);
    localparam int NBYTES = WIDTH / 8;

    logic [WIDTH-1:0] count_n, reload_n;

    assign rollover = step && (&count);

    always_comb begin
        count_n  = count;
        reload_n = reload;
        if (trig_reload) begin
            count_n = reload;
        end else if (step) begin
            if (rollover) count_n = reload_on_roll ? reload : '0;
            else          count_n = count + 1'b1;
        end
        if (trig_capture) reload_n = count;
        for (int i = 0; i < NBYTES; i++) begin
            if (cnt_be[i]) count_n[i*8 +: 8]  = wr_byte;
            if (rld_be[i]) reload_n[i*8 +: 8] = wr_byte;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count  <= '0;
            reload <= '0;
        end else begin
            count  <= count_n;
            reload <= reload_n;
        end
    end

    // R2: no step, no trigger reload, no write -> count unchanged
    a_r2_hold: assert property (@(posedge clk) disable iff (rst)
        (!step && !trig_reload && cnt_be == '0) |=> $stable(count));

    // R4: rollover in wrap mode returns to zero
    a_r4_wrap_zero: assert property (@(posedge clk) disable iff (rst)
        (rollover && !reload_on_roll && !trig_reload && cnt_be == '0) |=> (count == '0));

    // R5: rollover in reload mode loads the reload value
    a_r5_roll_reload: assert property (@(posedge clk) disable iff (rst)
        (rollover && reload_on_roll && cnt_be == '0) |=> (count == $past(reload)));

endmodule

// File: rtl/capture_reload_timer.sv
module capture_reload_timer
    import crt_pkg::*;
#(
    parameter int WIDTH  = 16,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_en,
    input  logic              cnt_pin,
    input  logic              trig_pin,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data,
    output logic              ovf_flag,
    output logic              ext_flag,
    output logic              irq,
    output logic              baud_pulse
);
    localparam int NBYTES   = WIDTH / 8;
    localparam int CNT_BASE = CTRL_ADDR + 1;
    localparam int RLD_BASE = CNT_BASE + NBYTES;
    localparam int NPINS    = 2;

    ctrl_t            ctrl;
    mode_e            mode;
    logic [NPINS-1:0] pins, falls;
    logic             step, trig, rollover, ctrl_wr, pulse_q;
    logic [NBYTES-1:0] cnt_be, rld_be;
    logic [WIDTH-1:0] count, reload;

    assign pins = {trig_pin, cnt_pin};

    for (genvar p = 0; p < NPINS; p++) begin : g_sync
        crt_edge_sync u_sync (
            .clk (clk),
            .rst (rst),
            .pin (pins[p]),
            .fall(falls[p])
        );
    end

    assign mode    = decode_mode(ctrl);
    assign step    = ctrl.run && (ctrl.cnt_src ? falls[0] : tick_en);
    assign trig    = ctrl.ext_en && (mode != MODE_BAUD) && falls[1];
    assign ctrl_wr = wr_en && (wr_addr == ADDR_W'(CTRL_ADDR));

    for (genvar b = 0; b < NBYTES; b++) begin : g_be
        assign cnt_be[b] = wr_en && (wr_addr == ADDR_W'(CNT_BASE + b));
        assign rld_be[b] = wr_en && (wr_addr == ADDR_W'(RLD_BASE + b));
    end

    crt_ctrl u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .wr     (ctrl_wr),
        .wr_data(wr_data),
        .set_ovf(rollover && (mode != MODE_BAUD)),
        .set_ext(trig),
        .ctrl   (ctrl)
    );

    crt_counter #(.WIDTH(WIDTH)) u_cnt (
        .clk           (clk),
        .rst           (rst),
        .step          (step),
        .reload_on_roll(mode != MODE_CAPTURE),
        .trig_reload   (trig && (mode == MODE_RELOAD)),
        .trig_capture  (trig && (mode == MODE_CAPTURE)),
        .cnt_be        (cnt_be),
        .rld_be        (rld_be),
        .wr_byte       (wr_data),
        .count         (count),
        .reload        (reload),
        .rollover      (rollover)
    );

    always_ff @(posedge clk) begin
        if (rst) pulse_q <= 1'b0;
        else     pulse_q <= rollover && (mode == MODE_BAUD);
    end

    always_comb begin
        rd_data = '0;
        if (rd_addr == ADDR_W'(CTRL_ADDR)) rd_data = ctrl;
        for (int i = 0; i < NBYTES; i++) begin
            if (rd_addr == ADDR_W'(CNT_BASE + i)) rd_data = count[i*8 +: 8];
            if (rd_addr == ADDR_W'(RLD_BASE + i)) rd_data = reload[i*8 +: 8];
        end
    end

    assign ovf_flag   = ctrl.ovf;
    assign ext_flag   = ctrl.ext;
    assign irq        = ctrl.ovf | ctrl.ext;
    assign baud_pulse = pulse_q;

    // R9: a baud pulse always follows a rollover taken in baud mode
    a_r9_pulse_cause: assert property (@(posedge clk) disable iff (rst)
        $rose(baud_pulse) |-> $past(rollover));

endmodule

// File: tb/capture_reload_timer_test.sv
`timescale 1ns/1ps
module capture_reload_timer_test;
    logic       clk = 0, rst = 1;
    logic       tick_en = 0, cnt_pin = 0, trig_pin = 0, wr_en = 0;
    logic [2:0] wr_addr = 0, rd_addr = 0;
    logic [7:0] wr_data = 0;
    logic [7:0] rd_data;
    logic       ovf_flag, ext_flag, irq, baud_pulse;

    int checks = 0, errors = 0, cycles = 0, pulses = 0;
    string phase = "R1";

    // behavioural reference state
    logic [15:0] m_cnt = 0, m_rld = 0;
    logic [7:0]  m_ctrl = 0;
    logic        m_pulse = 0;
    logic [2:0]  c_hist = 0, t_hist = 0;   // [0] newest sample

    capture_reload_timer uut (.*);

    always #4 clk = ~clk;

    always @(posedge clk) begin
        logic fc, ft, baud, capm, stp, trg, roll;
        logic [15:0] ncnt, nrld;
        logic [7:0]  nctrl;
        cycles++;
        if (rst) begin
            m_cnt = 0; m_rld = 0; m_ctrl = 0; m_pulse = 0; c_hist = 0; t_hist = 0;
        end else begin
            fc   = c_hist[2] && !c_hist[1];
            ft   = t_hist[2] && !t_hist[1];
            baud = m_ctrl[5] || m_ctrl[4];
            capm = m_ctrl[0] && !baud;
            stp  = m_ctrl[2] && (m_ctrl[1] ? fc : tick_en);
            trg  = m_ctrl[3] && !baud && ft;
            roll = stp && (m_cnt == 16'hFFFF);
            ncnt = m_cnt; nrld = m_rld; nctrl = m_ctrl;
            if (trg && !capm)  ncnt = m_rld;
            else if (stp)      ncnt = roll ? (capm ? 16'h0 : m_rld) : m_cnt + 16'd1;
            if (trg && capm)   nrld = m_cnt;
            if (wr_en) case (wr_addr)
                3'd0: nctrl = wr_data;
                3'd1: ncnt[7:0]  = wr_data;
                3'd2: ncnt[15:8] = wr_data;
                3'd3: nrld[7:0]  = wr_data;
                3'd4: nrld[15:8] = wr_data;
                default: ;
            endcase
            if (roll && !baud) nctrl[7] = 1'b1;
            if (trg)           nctrl[6] = 1'b1;
            m_pulse = roll && baud;
            m_cnt = ncnt; m_rld = nrld; m_ctrl = nctrl;
            c_hist = {c_hist[1:0], cnt_pin};
            t_hist = {t_hist[1:0], trig_pin};
        end
        if (cycles > 60000) begin
            errors++;
            $display("FAIL watchdog: run did not end, got %0d cycles expected fewer", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic check(input string tag, input string what, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
        end
    endtask

    task automatic rdreg(input int a, output logic [7:0] v);
        rd_addr = 3'(a);
        #0.1;
        v = rd_data;
    endtask

    // advance one clock and compare everything against the model
    task automatic cyc();
        logic [7:0] v;
        @(posedge clk);
        @(negedge clk);
        if (baud_pulse) pulses++;
        rdreg(0, v); check(phase, "control", v, m_ctrl);
        rdreg(1, v); check(phase, "count lo", v, m_cnt[7:0]);
        rdreg(2, v); check(phase, "count hi", v, m_cnt[15:8]);
        rdreg(3, v); check(phase, "reload lo", v, m_rld[7:0]);
        rdreg(4, v); check(phase, "reload hi", v, m_rld[15:8]);
        check(phase, "ovf_flag", ovf_flag, m_ctrl[7]);
        check(phase, "ext_flag", ext_flag, m_ctrl[6]);
        check(phase, "irq", irq, m_ctrl[7] | m_ctrl[6]);
        check(phase, "baud_pulse", baud_pulse, m_pulse);
    endtask

    task automatic run_n(input int n);
        for (int i = 0; i < n; i++) cyc();
    endtask

    task automatic wr(input int a, input int d);
        wr_en = 1; wr_addr = 3'(a); wr_data = 8'(d);
        cyc();
        wr_en = 0;
    endtask

    task automatic wr16(input int base, input int v);
        wr(base, v & 8'hFF);
        wr(base + 1, (v >> 8) & 8'hFF);
    endtask

    task automatic pin_fall(input bit trig);
        if (trig) trig_pin = 1; else cnt_pin = 1;
        run_n(2);
        if (trig) trig_pin = 0; else cnt_pin = 0;
        run_n(4);
    endtask

    initial begin
        logic [7:0] v, lo, hi, a, b;
        @(negedge clk);
        run_n(2);
        rst = 0;
        cyc();
        phase = "R1";
        rdreg(0, v); check("R1", "reset control", v, 0);
        rdreg(2, v); check("R1", "reset count hi", v, 0);
        check("R1", "reset irq", irq, 0);

        phase = "R2";
        wr16(3, 16'h1234);
        tick_en = 1; run_n(5); tick_en = 0;
        rdreg(1, v); check("R2", "count with run off", v, 0);
        wr(0, 8'h04);
        tick_en = 1; run_n(7); tick_en = 0; run_n(2);
        rdreg(1, v); check("R2", "count after 7 ticks", v, 7);

        phase = "R11";
        tick_en = 1; wr(1, 8'h55); tick_en = 0;
        rdreg(1, v); check("R11", "write beats increment", v, 8'h55);

        phase = "R4";
        wr(0, 8'h01);
        wr16(1, 16'hFFFE);
        wr(0, 8'h05);
        tick_en = 1; run_n(3); tick_en = 0;
        check("R4", "overflow flag set", ovf_flag, 1);
        rdreg(1, v); check("R4", "wrapped count", v, 1);
        phase = "R10";
        check("R10", "irq with overflow", irq, 1);
        run_n(3);
        check("R4", "flag still set", ovf_flag, 1);
        wr(0, 8'h05);
        check("R10", "irq after clear", irq, 0);

        phase = "R5";
        wr(0, 8'h00);
        wr16(1, 16'hFFFF);
        wr(0, 8'h04);
        tick_en = 1; cyc(); tick_en = 0;
        rdreg(2, hi); rdreg(1, lo); check("R5", "reloaded count", {hi, lo}, 16'h1234);
        wr(0, 8'h04);

        phase = "R3";
        wr16(1, 16'h0000);
        wr(0, 8'h06);
        pin_fall(0); pin_fall(0); pin_fall(0);
        rdreg(1, v); check("R3", "three pin falls", v, 3);
        cnt_pin = 1; run_n(2);
        rdreg(1, v); check("R3", "rising edge ignored", v, 3);
        cnt_pin = 0; run_n(4);

        phase = "R6";
        wr(0, 8'h0D);
        tick_en = 1;
        pin_fall(1);
        tick_en = 0;
        check("R6", "external flag on capture", ext_flag, 1);
        wr(0, 8'h0D);

        phase = "R7";
        wr16(3, 16'hABCD);
        wr(0, 8'h0C);
        pin_fall(1);
        rdreg(2, hi); rdreg(1, lo); check("R7", "trigger reload", {hi, lo}, 16'hABCD);
        check("R7", "external flag on reload", ext_flag, 1);
        wr(0, 8'h04);

        phase = "R8";
        wr(0, 8'h05);
        rdreg(3, a);
        pin_fall(1);
        check("R8", "no flag with enable off", ext_flag, 0);
        rdreg(3, b); check("R8", "capture reg unchanged", b, a);

        phase = "R9";
        wr(0, 8'h00);
        wr16(3, 16'hFFFC);
        wr16(1, 16'hFFFD);
        pulses = 0;
        wr(0, 8'h3D);
        tick_en = 1; run_n(8);
        pin_fall(1);
        tick_en = 0; run_n(2);
        check("R9", "baud pulses seen", pulses > 0, 1);
        check("R9", "no overflow flag in baud", ovf_flag, 0);
        check("R9", "trigger ignored in baud", ext_flag, 0);

        phase = "R11";
        rst = 1; run_n(2); rst = 0; cyc();
        rdreg(3, v); check("R1", "reload after reset", v, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule